// File: doc/BRIEF.md
# Divided Clock Tap Generator

This block turns one free-running primary clock into three clock-like outputs. The primary clock leaves the block unchanged. Two slower outputs are also produced. Each slow output is chosen from four fixed positions along an internal binary divider. With the default settings these positions divide by 16, 512, 16384 and 524288, so an 8 MHz input gives roughly 500 kHz, 16 kHz, 490 Hz and 15 Hz.

The divider is a synchronous up-counter. A chosen divider bit does not drive an output directly. It first passes through a register clocked by the primary clock, so each slow output changes only on a rising primary edge and cannot glitch. Each of the two outputs has its own 2-bit select code. The block treats both codes as static configuration and captures them while reset is held. Either tap may be picked for both outputs.

An enable input starts and stops the whole divider. When the enable is low, the counter returns to zero and both slow outputs are forced low. The block has no data path, so there is no valid/ready handshake. All pins are plain control or clock signals.

Top module: `osc_tap_divider`

## Requirements
- R1: The slow output for tap number k (default k = 4, 9, 14 or 19) has a period of exactly 2^k primary cycles. It stays high for 2^(k-1) cycles and low for 2^(k-1) cycles, and it changes only on a rising primary edge.
- R2: Select code 2'b00 picks tap parameter TAP_K0, 2'b01 picks TAP_K1, 2'b10 picks TAP_K2 and 2'b11 picks TAP_K3. Consider the j-th enabled rising edge after reset or after re-enable, where the first such edge is j = 1. Just after that edge, the output for tap k equals bit (k-1) of the value j-1.
- R3: A rising edge with en_i low clears the counter. From that edge on, both slow outputs read 0. Once en_i returns high, counting restarts from zero.
- R4: Synchronous reset (rst_i high at a rising edge) clears the counter and both slow outputs to 0.
- R5: When both select codes name the same tap, div_a_o and div_b_o are identical on every cycle.
- R6: The select inputs are captured only on edges where rst_i is high. Changing them after reset is released has no effect on either output until the next reset.
- R7: clk_o always equals clk_i.
- R8: Every enabled rising edge that is not a reset edge advances the divider count by exactly one, wrapping at its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running primary clock |
| rst_i | input | 1 | Synchronous active-high reset, also captures the selects |
| en_i | input | 1 | Run enable; low clears the divider and forces the slow outputs low |
| sel_a_i | input | 2 | Tap select code for output A |
| sel_b_i | input | 2 | Tap select code for output B |
| clk_o | output | 1 | Pass-through copy of the primary clock |
| div_a_o | output | 1 | Resynchronized divided clock A |
| div_b_o | output | 1 | Resynchronized divided clock B |

## Verification
The bench builds the block with taps 1, 3, 5 and 8 instead of 4, 9, 14 and 19. This shortens the longest period from half a million cycles to 256. With that change, every select code, a full wrap of the counter and the exact high-phase length of a mid tap all fit in short runs. Because the tap positions are parameters, the same select decoding and resynchronizing paths that the default build uses are the ones being exercised.

// File: rtl/osc_div_pkg.sv
package osc_div_pkg;
  localparam int unsigned N_TAPS = 4;
  localparam int unsigned N_OUTS = 2;

  typedef enum logic [1:0] {
    TAP_SEL_0 = 2'b00,
    TAP_SEL_1 = 2'b01,
    TAP_SEL_2 = 2'b10,
    TAP_SEL_3 = 2'b11
  } tap_sel_e;
endpackage

// File: rtl/osc_div_counter.sv
module osc_div_counter #(
  parameter int unsigned W = 19
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) cnt_o <= '0;
    else                cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/osc_div_tap_pick.sv
module osc_div_tap_pick
  import osc_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [N_TAPS-1:0] taps_i,
  input  logic [1:0]        sel_i,
  output tap_sel_e          sel_q_o,
  output logic              div_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) sel_q_o <= tap_sel_e'(sel_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) div_o <= 1'b0;
    else                div_o <= taps_i[sel_q_o];
  end
endmodule

// File: rtl/osc_tap_divider.sv
module osc_tap_divider
  import osc_div_pkg::*;
#(
  parameter int unsigned TAP_K0 = 4,
  parameter int unsigned TAP_K1 = 9,
  parameter int unsigned TAP_K2 = 14,
  parameter int unsigned TAP_K3 = 19
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       en_i,
  input  logic [1:0] sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       clk_o,
  output logic       div_a_o,
  output logic       div_b_o
);
  localparam int unsigned CNT_W = TAP_K3;
  localparam int unsigned TAP_K [N_TAPS] = '{TAP_K0, TAP_K1, TAP_K2, TAP_K3};

  logic [CNT_W-1:0]  cnt;
  logic [N_TAPS-1:0] taps;
  logic [1:0]        sel_raw [N_OUTS];
  tap_sel_e          sel_q   [N_OUTS];
  logic              div     [N_OUTS];

  assign clk_o = clk_i;

  osc_div_counter #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .cnt_o (cnt)
  );

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign taps[t] = cnt[TAP_K[t]-1];
  end

  assign sel_raw[0] = sel_a_i;
  assign sel_raw[1] = sel_b_i;

  for (genvar o = 0; o < N_OUTS; o++) begin : g_out
    osc_div_tap_pick u_pick (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (en_i),
      .taps_i  (taps),
      .sel_i   (sel_raw[o]),
      .sel_q_o (sel_q[o]),
      .div_o   (div[o])
    );
  end

  assign div_a_o = div[0];
  assign div_b_o = div[1];
endmodule

// File: rtl/osc_tap_divider_chk.sv
module osc_tap_divider_chk #(
  parameter int unsigned W = 19
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         en_i,
  input logic [W-1:0] cnt,
  input logic [1:0]   sel_a_q,
  input logic [1:0]   sel_b_q,
  input logic         div_a_o,
  input logic         div_b_o
);
  // R3
  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!div_a_o && !div_b_o));

  // R5
  a_r5_same_tap_equal: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && sel_a_q == sel_b_q) |=> (div_a_o == div_b_o));

  // R6
  a_r6_sel_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ($stable(sel_a_q) && $stable(sel_b_q)));

  // R8
  a_r8_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (cnt == W'($past(cnt) + W'(1))));

  // R3
  a_r3_count_cleared: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (cnt == '0));
endmodule

bind osc_tap_divider osc_tap_divider_chk #(.W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .en_i    (en_i),
  .cnt     (cnt),
  .sel_a_q (sel_q[0]),
  .sel_b_q (sel_q[1]),
  .div_a_o (div_a_o),
  .div_b_o (div_b_o)
);

// File: tb/tb_osc_tap_divider.sv
`timescale 1ns/1ps
module tb_osc_tap_divider;
  localparam int unsigned K0 = 1, K1 = 3, K2 = 5, K3 = 8;
  localparam int unsigned WD = 200000;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [1:0] sel_a = 2'b00, sel_b = 2'b00;
  logic clk_o, div_a, div_b;
  int checks = 0, fails = 0;

  osc_tap_divider #(.TAP_K0(K0), .TAP_K1(K1), .TAP_K2(K2), .TAP_K3(K3)) dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .clk_o(clk_o), .div_a_o(div_a), .div_b_o(div_b)
  );

  always #2.5 clk = ~clk;

  function automatic int unsigned kbit(input logic [1:0] s);
    case (s)
      2'b00: return K0 - 1;
      2'b01: return K1 - 1;
      2'b10: return K2 - 1;
      default: return K3 - 1;
    endcase
  endfunction

  // Reference built from R2, R3, R4, R6
  logic [K3-1:0] m = '0;
  logic [1:0] ms_a = 2'b00, ms_b = 2'b00;
  logic ea = 1'b0, eb = 1'b0;
  always @(posedge clk) begin
    if (rst) begin
      ms_a <= sel_a; ms_b <= sel_b; m <= '0; ea <= 1'b0; eb <= 1'b0;
    end else if (!en) begin
      m <= '0; ea <= 1'b0; eb <= 1'b0;
    end else begin
      m <= m + 1'b1; ea <= m[kbit(ms_a)]; eb <= m[kbit(ms_b)];
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk); rst = 1'b1; en = 1'b1; sel_a = a; sel_b = b;
    repeat (2) @(negedge clk);
    chk("R4 div_a in reset", div_a, 1'b0);
    chk("R4 div_b in reset", div_b, 1'b0);
    rst = 1'b0;
  endtask

  task automatic run_cmp(input string req, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (div_a !== ea || div_b !== eb) begin
        bad++;
        if (bad == 1) $display("FAIL %s: actual a=%b b=%b expected a=%b b=%b at %0t",
                               req, div_a, div_b, ea, eb, $time);
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic t_patterns();
    do_reset(2'b00, 2'b01); run_cmp("R2 sel 00/01", 300);
    do_reset(2'b10, 2'b11); run_cmp("R2 sel 10/11 with wrap", 600);
  endtask

  task automatic t_same_tap();
    int diff = 0;
    do_reset(2'b11, 2'b11);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (div_a !== div_b) diff++;
    end
    chk("R5 identical outputs", diff == 0, 1'b1);
  endtask

  task automatic t_duty();
    int hi = 0, per = 0;
    do_reset(2'b01, 2'b10);
    // R1: first high phase of tap K1 starts after 2^(K1-1)+1 edges
    repeat ((1 << (K1 - 1)) + 1) @(negedge clk);
    chk("R1 first rise of tap K1", div_a, 1'b1);
    while (div_a === 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
    chk("R1 high phase length", hi == (1 << (K1 - 1)), 1'b1);
    while (div_a === 1'b0 && per < 1000) begin per++; @(negedge clk); end
    chk("R1 low phase length", per == (1 << (K1 - 1)), 1'b1);
  endtask

  task automatic t_enable();
    do_reset(2'b00, 2'b10);
    repeat (13) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R3 div_a low when disabled", div_a, 1'b0);
    chk("R3 div_b low when disabled", div_b, 1'b0);
    repeat (7) @(negedge clk);
    chk("R3 still low", div_a | div_b, 1'b0);
    en = 1'b1;
    run_cmp("R3 restart from zero", 200);
  endtask

  task automatic t_sel_frozen();
    do_reset(2'b00, 2'b01);
    repeat (3) @(negedge clk);
    sel_a = 2'b11; sel_b = 2'b10;
    run_cmp("R6 sel change ignored", 300);
  endtask

  task automatic t_pass();
    @(posedge clk); #1;
    chk("R7 clk_o high phase", clk_o, 1'b1);
    @(negedge clk); #1;
    chk("R7 clk_o low phase", clk_o, 1'b0);
  endtask

  task automatic t_wrap();
    int hits = 0;
    do_reset(2'b11, 2'b00);
    // R8: tap K3 is the counter top bit, rises once per 2^K3 cycles
    for (int i = 0; i < (1 << K3) * 2; i++) begin
      @(negedge clk);
      if (div_a === 1'b1 && i > 0) hits++;
    end
    chk("R8 top tap high half the time", hits == (1 << K3), 1'b1);
  endtask

  initial begin
    #(WD * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_pass();
    t_patterns();
    t_same_tap();
    t_duty();
    t_enable();
    t_sel_frozen();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule